// File: doc/BRIEF.md
# Instruction extension-prefix decoder

This block sits on a stream of instruction bytes that arrives one byte per cycle in which `in_valid` is high. It looks at the byte in the lead position and decides whether it opens an extension prefix. Five forms are recognised: a one-byte register-extension prefix (0x40 to 0x4F), a two-byte register-extension prefix (lead 0xD5), a two-byte vector prefix (lead 0xC5), a three-byte vector prefix (lead 0xC4) and a four-byte extended vector prefix (lead 0x62). The lead byte sets how many payload bytes follow. The block collects them and then issues a single normalised record.

In the record every field that the encoding stores complemented has been turned back to true polarity, so a 1 always means active. Compact map codes become one map number, and the two-bit mandatory-prefix code becomes the prefix byte it stands for. The byte after a prefix is always forwarded as the opcode byte, whatever its value. A byte in the lead position that opens no prefix produces a record of kind NONE and is forwarded as the opcode in the same cycle. Stalls, meaning cycles with `in_valid` low, freeze the collection state. Every output is registered and appears on the cycle after the byte that causes it.

Top module: `xpfx_decoder`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `rec_valid` and `op_valid` are 0. The decoder starts by treating the next accepted byte as a lead byte.
- R2: A lead byte 0100WRXB (0x40 to 0x4F) produces a record on the next cycle with `rec_kind`=1, `rec_w`=W, `rec_r`={0,R}, `rec_x`={0,X} and `rec_b`={0,B}. All other fields are 0.
- R3: Lead 0xD5 followed by one payload byte MRXBWRXB (bit 7 down to bit 0) produces `rec_kind`=2 on the cycle after the payload byte. The fields are `rec_map`=M, `rec_r`={bit6,bit2}, `rec_x`={bit5,bit1}, `rec_b`={bit4,bit0} and `rec_w`=bit3. No record is issued after the lead byte alone.
- R4: Lead 0xC5 followed by payload P produces `rec_kind`=3. The fields are `rec_r`={0,~P[7]}, `rec_vreg`={0,~P[6:3]}, `rec_vlen`={0,P[2]} and `rec_map`=1, and `rec_w` is 0.
- R5: Lead 0xC4 followed by P1 and P2 produces `rec_kind`=4. The fields are `rec_r`, `rec_x` and `rec_b` = {0,~P1[7]}, {0,~P1[6]} and {0,~P1[5]}, `rec_map`=P1[4:0], `rec_w`=P2[7], `rec_vreg`={0,~P2[6:3]} and `rec_vlen`={0,P2[2]}.
- R6: Lead 0x62 followed by P1, P2 and P3 produces `rec_kind`=5. The fields are `rec_r`={~P1[4],~P1[7]}, `rec_x`={~P2[2],~P1[6]}, `rec_b`={P1[3],~P1[5]}, `rec_map`=P1[2:0] and `rec_w`=P2[7]. `rec_vreg` is {~P3[3],~P2[6:3]}, `rec_zmerge`=P3[7], `rec_vlen`=P3[6:5] (L',L), `rec_bctl`=P3[4] and `rec_mask`=P3[2:0].
- R7: For the vector forms, the two-bit prefix code (P[1:0] of the last byte that carries it) sets `rec_mand` to 0x00, 0x66, 0xF2 or 0xF3 for codes 0, 1, 2 and 3. The other forms report 0x00.
- R8: A lead-position byte that opens no prefix gives `rec_valid`=1 with `rec_kind`=0 and all fields 0. On the same cycle `op_valid`=1 and `op_byte` equals that byte.
- R9: Cycles with `in_valid` low change no collection state and produce no `rec_valid` or `op_valid` pulse. A prefix with stalls between its bytes decodes exactly as without them.
- R10: `rec_valid` is a one-cycle pulse for a prefix record. The next accepted byte is forwarded as the opcode, with `op_valid`=1 and `rec_valid`=0 on the following cycle, even if its value matches a lead pattern. The decoder then returns to lead position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte on `in_byte` is accepted this cycle |
| in_byte | input | 8 | Instruction byte |
| rec_valid | output | 1 | One-cycle pulse: record fields are new |
| rec_kind | output | 3 | 0 none, 1 REX-1, 2 REX-2, 3 VEX-2, 4 VEX-3, 5 EVEX |
| rec_r | output | 2 | Register extension bits {bit4, bit3}, true polarity |
| rec_x | output | 2 | Index extension bits {bit4, bit3}, true polarity |
| rec_b | output | 2 | Base extension bits {bit4, bit3}, true polarity |
| rec_w | output | 1 | Operand-size bit |
| rec_vreg | output | 5 | Additional source register number, true polarity |
| rec_vlen | output | 2 | Vector length code (0: 128, 1: 256, 2: 512) or rounding field |
| rec_map | output | 5 | Opcode map number (1: 0F, 2: 0F38, 3: 0F3A) |
| rec_mand | output | 8 | Implied mandatory prefix byte, 0x00 if none |
| rec_zmerge | output | 1 | Zeroing/merging select, passed through |
| rec_bctl | output | 1 | Broadcast / rounding / suppression control bit |
| rec_mask | output | 3 | Mask register field |
| op_valid | output | 1 | One-cycle pulse: `op_byte` is new |
| op_byte | output | 8 | Forwarded opcode byte |

## Verification
The block has no top-level parameters. The bench builds it with the package constants: an eight-bit byte and a payload buffer of three bytes. Three bytes is the longest payload, so the four-byte form fills every buffer slot and its last payload byte lands in the highest index. The chosen payload values put inverted and non-inverted ones in every field position, and the stall cases exercise the buffer holding partial payloads across idle cycles.

// File: rtl/xpfx_pkg.sv
package xpfx_pkg;

    localparam int BYTE_W  = 8;
    localparam int MAX_PAY = 3;
    localparam int VREG_W  = 5;
    localparam int MAP_W   = 5;
    localparam int VLEN_W  = 2;
    localparam int MASK_W  = 3;
    localparam int CNT_W   = $clog2(MAX_PAY + 1);

    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t LEAD_RX2  = 8'hD5;
    localparam byte_t LEAD_VX2  = 8'hC5;
    localparam byte_t LEAD_VX3  = 8'hC4;
    localparam byte_t LEAD_EVX  = 8'h62;
    localparam logic [3:0] RX1_HI = 4'h4;

    typedef enum logic [2:0] {
        K_NONE = 3'd0,
        K_RX1  = 3'd1,
        K_RX2  = 3'd2,
        K_VX2  = 3'd3,
        K_VX3  = 3'd4,
        K_EVX  = 3'd5
    } kind_e;

    typedef struct packed {
        kind_e               kind;
        logic [1:0]          r;
        logic [1:0]          x;
        logic [1:0]          b;
        logic                w;
        logic [VREG_W-1:0]   vreg;
        logic [VLEN_W-1:0]   vlen;
        logic [MAP_W-1:0]    map;
        byte_t               mand;
        logic                zmerge;
        logic                bctl;
        logic [MASK_W-1:0]   mask;
    } rec_t;

    function automatic byte_t pp_to_prefix(input logic [1:0] pp);
        byte_t res;
        case (pp)
            2'd1:    res = 8'h66;
            2'd2:    res = 8'hF2;
            2'd3:    res = 8'hF3;
            default: res = 8'h00;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/xpfx_lead_classify.sv
module xpfx_lead_classify
    import xpfx_pkg::*;
(
    input  byte_t              lead,
    output kind_e              kind,
    output logic [CNT_W-1:0]   pay_len
);

    always_comb begin
        kind    = K_NONE;
        pay_len = '0;
        if (lead[BYTE_W-1:4] == RX1_HI) begin
            kind    = K_RX1;
            pay_len = CNT_W'(0);
        end else begin
            case (lead)
                LEAD_RX2: begin kind = K_RX2; pay_len = CNT_W'(1); end
                LEAD_VX2: begin kind = K_VX2; pay_len = CNT_W'(1); end
                LEAD_VX3: begin kind = K_VX3; pay_len = CNT_W'(2); end
                LEAD_EVX: begin kind = K_EVX; pay_len = CNT_W'(MAX_PAY); end
                default:  begin kind = K_NONE; pay_len = '0; end
            endcase
        end
    end

endmodule

// File: rtl/xpfx_field_map.sv
module xpfx_field_map
    import xpfx_pkg::*;
(
    input  kind_e                    kind,
    input  byte_t [MAX_PAY-1:0]      pay,
    output rec_t                     rec
);

    byte_t p0;
    byte_t p1;
    byte_t p2;

    always_comb begin
        p0 = pay[0];
        p1 = pay[1];
        p2 = pay[2];
        rec      = '0;
        rec.kind = kind;
        case (kind)
            K_RX1: begin
                rec.w = p0[3];
                rec.r = {1'b0, p0[2]};
                rec.x = {1'b0, p0[1]};
                rec.b = {1'b0, p0[0]};
            end
            K_RX2: begin
                rec.map = MAP_W'(p0[7]);
                rec.r   = {p0[6], p0[2]};
                rec.x   = {p0[5], p0[1]};
                rec.b   = {p0[4], p0[0]};
                rec.w   = p0[3];
            end
            K_VX2: begin
                rec.r    = {1'b0, ~p0[7]};
                rec.vreg = {1'b0, ~p0[6:3]};
                rec.vlen = {1'b0, p0[2]};
                rec.mand = pp_to_prefix(p0[1:0]);
                rec.map  = MAP_W'(1);
            end
            K_VX3: begin
                rec.r    = {1'b0, ~p0[7]};
                rec.x    = {1'b0, ~p0[6]};
                rec.b    = {1'b0, ~p0[5]};
                rec.map  = p0[4:0];
                rec.w    = p1[7];
                rec.vreg = {1'b0, ~p1[6:3]};
                rec.vlen = {1'b0, p1[2]};
                rec.mand = pp_to_prefix(p1[1:0]);
            end
            K_EVX: begin
                rec.r      = {~p0[4], ~p0[7]};
                rec.x      = {~p1[2], ~p0[6]};
                rec.b      = {p0[3], ~p0[5]};
                rec.map    = MAP_W'(p0[2:0]);
                rec.w      = p1[7];
                rec.vreg   = {~p2[3], ~p1[6:3]};
                rec.mand   = pp_to_prefix(p1[1:0]);
                rec.zmerge = p2[7];
                rec.vlen   = p2[6:5];
                rec.bctl   = p2[4];
                rec.mask   = p2[2:0];
            end
            default: begin
                rec      = '0;
                rec.kind = K_NONE;
            end
        endcase
    end

endmodule

// File: rtl/xpfx_decoder.sv
module xpfx_decoder
    import xpfx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [7:0]           in_byte,
    output logic                 rec_valid,
    output logic [2:0]           rec_kind,
    output logic [1:0]           rec_r,
    output logic [1:0]           rec_x,
    output logic [1:0]           rec_b,
    output logic                 rec_w,
    output logic [4:0]           rec_vreg,
    output logic [1:0]           rec_vlen,
    output logic [4:0]           rec_map,
    output logic [7:0]           rec_mand,
    output logic                 rec_zmerge,
    output logic                 rec_bctl,
    output logic [2:0]           rec_mask,
    output logic                 op_valid,
    output logic [7:0]           op_byte
);

    typedef enum logic [1:0] {
        ST_LEAD = 2'd0,
        ST_PAY  = 2'd1,
        ST_OP   = 2'd2
    } state_e;

    typedef struct packed {
        state_e               state;
        kind_e                kind;
        logic [CNT_W-1:0]     left;
        logic [CNT_W-1:0]     idx;
        byte_t [MAX_PAY-1:0]  pay;
        rec_t                 rec;
        logic                 rec_valid;
        logic                 op_valid;
        byte_t                op_byte;
    } dec_t;

    dec_t                 s_d;
    dec_t                 s_q;

    kind_e                lead_kind;
    logic [CNT_W-1:0]     lead_len;
    kind_e                map_kind;
    byte_t [MAX_PAY-1:0]  map_pay;
    byte_t [MAX_PAY-1:0]  merged;
    rec_t                 map_rec;

    xpfx_lead_classify u_classify (
        .lead    (in_byte),
        .kind    (lead_kind),
        .pay_len (lead_len)
    );

    xpfx_field_map u_fields (
        .kind (map_kind),
        .pay  (map_pay),
        .rec  (map_rec)
    );

    // payload buffer with the incoming byte placed in its slot
    always_comb begin
        for (int i = 0; i < MAX_PAY; i++) begin
            merged[i] = (CNT_W'(i) == s_q.idx) ? in_byte : s_q.pay[i];
        end
    end

    always_comb begin
        if (s_q.state == ST_LEAD) begin
            map_kind   = lead_kind;
            map_pay    = '0;
            map_pay[0] = in_byte;
        end else begin
            map_kind = s_q.kind;
            map_pay  = merged;
        end
    end

    always_comb begin
        s_d           = s_q;
        s_d.rec_valid = 1'b0;
        s_d.op_valid  = 1'b0;
        if (in_valid) begin
            case (s_q.state)
                ST_LEAD: begin
                    case (lead_kind)
                        K_NONE: begin
                            s_d.rec       = map_rec;
                            s_d.rec_valid = 1'b1;
                            s_d.op_valid  = 1'b1;
                            s_d.op_byte   = in_byte;
                        end
                        K_RX1: begin
                            s_d.rec       = map_rec;
                            s_d.rec_valid = 1'b1;
                            s_d.state     = ST_OP;
                        end
                        default: begin
                            s_d.kind  = lead_kind;
                            s_d.left  = lead_len;
                            s_d.idx   = '0;
                            s_d.pay   = '0;
                            s_d.state = ST_PAY;
                        end
                    endcase
                end
                ST_PAY: begin
                    s_d.pay = merged;
                    if (s_q.left == CNT_W'(1)) begin
                        s_d.rec       = map_rec;
                        s_d.rec_valid = 1'b1;
                        s_d.state     = ST_OP;
                    end else begin
                        s_d.left = s_q.left - CNT_W'(1);
                        s_d.idx  = s_q.idx + CNT_W'(1);
                    end
                end
                ST_OP: begin
                    s_d.op_valid = 1'b1;
                    s_d.op_byte  = in_byte;
                    s_d.state    = ST_LEAD;
                end
                default: begin
                    s_d.state = ST_LEAD;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rec_valid  = s_q.rec_valid;
    assign rec_kind   = s_q.rec.kind;
    assign rec_r      = s_q.rec.r;
    assign rec_x      = s_q.rec.x;
    assign rec_b      = s_q.rec.b;
    assign rec_w      = s_q.rec.w;
    assign rec_vreg   = s_q.rec.vreg;
    assign rec_vlen   = s_q.rec.vlen;
    assign rec_map    = s_q.rec.map;
    assign rec_mand   = s_q.rec.mand;
    assign rec_zmerge = s_q.rec.zmerge;
    assign rec_bctl   = s_q.rec.bctl;
    assign rec_mask   = s_q.rec.mask;
    assign op_valid   = s_q.op_valid;
    assign op_byte    = s_q.op_byte;

endmodule

// File: rtl/xpfx_checker.sv
module xpfx_checker (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       rec_valid,
    input logic [2:0] rec_kind,
    input logic       rec_w,
    input logic [4:0] rec_map,
    input logic [7:0] rec_mand,
    input logic       op_valid
);

    // R9: no output pulse without an accepted byte in the previous cycle
    a_r9_no_pulse_on_stall: assert property (@(posedge clk) disable iff (rst)
        !$past(in_valid) |-> (!rec_valid && !op_valid));

    // R10: a prefix record is never followed directly by another record
    a_r10_prefix_pulse: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_kind != 3'd0) |=> !rec_valid);

    // R8: an unmatched byte is forwarded together with its record
    a_r8_none_forwarded: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_kind == 3'd0) |-> op_valid);

    // R7: mandatory prefix byte is one of the four legal values
    a_r7_mand_legal: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> (rec_mand == 8'h00 || rec_mand == 8'h66 ||
                       rec_mand == 8'hF2 || rec_mand == 8'hF3));

    // R4: the two-byte vector form always implies map 1 and W clear
    a_r4_vx2_map: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_kind == 3'd3) |-> (rec_map == 5'd1 && !rec_w));

    // R2: kinds above 5 never appear
    a_r2_kind_range: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> (rec_kind <= 3'd5));

    // R1: outputs quiet on the cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!rec_valid && !op_valid));

endmodule

bind xpfx_decoder xpfx_checker u_xpfx_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .rec_valid (rec_valid),
    .rec_kind  (rec_kind),
    .rec_w     (rec_w),
    .rec_map   (rec_map),
    .rec_mand  (rec_mand),
    .op_valid  (op_valid)
);

// File: tb/xpfx_decoder_tb_top.sv
`timescale 1ns/100ps
module xpfx_decoder_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       rec_valid;
    logic [2:0] rec_kind;
    logic [1:0] rec_r;
    logic [1:0] rec_x;
    logic [1:0] rec_b;
    logic       rec_w;
    logic [4:0] rec_vreg;
    logic [1:0] rec_vlen;
    logic [4:0] rec_map;
    logic [7:0] rec_mand;
    logic       rec_zmerge;
    logic       rec_bctl;
    logic [2:0] rec_mask;
    logic       op_valid;
    logic [7:0] op_byte;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    xpfx_decoder dut_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_byte    (in_byte),
        .rec_valid  (rec_valid),
        .rec_kind   (rec_kind),
        .rec_r      (rec_r),
        .rec_x      (rec_x),
        .rec_b      (rec_b),
        .rec_w      (rec_w),
        .rec_vreg   (rec_vreg),
        .rec_vlen   (rec_vlen),
        .rec_map    (rec_map),
        .rec_mand   (rec_mand),
        .rec_zmerge (rec_zmerge),
        .rec_bctl   (rec_bctl),
        .rec_mask   (rec_mask),
        .op_valid   (op_valid),
        .op_byte    (op_byte)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(posedge clk);
        #1;
    endtask

    // idle cycles; each one must show no pulse (R9)
    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_byte  = 8'hA5;
            @(posedge clk);
            #1;
            check("R9 quiet during stall", {62'd0, rec_valid, op_valid}, 64'd0);
        end
    endtask

    // expects a record pulse with the given fields and no opcode pulse
    task automatic expect_rec(input string req, input logic [2:0] k, input logic [1:0] r,
                              input logic [1:0] x, input logic [1:0] b, input logic w,
                              input logic [4:0] v, input logic [1:0] vl, input logic [4:0] m,
                              input logic [7:0] md, input logic z, input logic bc,
                              input logic [2:0] mk, input logic opv);
        check(req, {29'd0, rec_valid, op_valid, rec_kind, rec_r, rec_x, rec_b, rec_w, rec_vreg,
                    rec_vlen, rec_map, rec_mand, rec_zmerge, rec_bctl, rec_mask},
                   {29'd0, 1'b1, opv, k, r, x, b, w, v, vl, m, md, z, bc, mk});
    endtask

    task automatic expect_op(input string req, input logic [7:0] b);
        check(req, {54'd0, rec_valid, op_valid, op_byte}, {54'd0, 1'b0, 1'b1, b});
    endtask

    task automatic expect_quiet(input string req);
        check(req, {62'd0, rec_valid, op_valid}, 64'd0);
    endtask

    task automatic t_reset;
        repeat (3) @(posedge clk);
        #1;
        check("R1 outputs low in reset", {62'd0, rec_valid, op_valid}, 64'd0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1 outputs low after reset", {62'd0, rec_valid, op_valid}, 64'd0);
    endtask

    task automatic t_rex1;
        push(8'h4D);
        expect_rec("R2 one-byte reg-ext record", 3'd1, 2'b01, 2'b00, 2'b01, 1'b1,
                   5'd0, 2'd0, 5'd0, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0);
        push(8'h62);
        expect_op("R10 lead-looking byte forwarded as opcode", 8'h62);
        gap(1);
    endtask

    task automatic t_rex2;
        push(8'hD5);
        expect_quiet("R3 no record after lead alone");
        push(8'hA6);
        expect_rec("R3 two-byte reg-ext record", 3'd2, 2'b01, 2'b11, 2'b00, 1'b0,
                   5'd0, 2'd0, 5'd1, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0);
        push(8'h8B);
        expect_op("R10 opcode after two-byte reg-ext", 8'h8B);
        gap(1);
    endtask

    task automatic t_vex2;
        push(8'hC5);
        push(8'h45);
        expect_rec("R4 R7 two-byte vector record, pp=1 -> 66", 3'd3, 2'b01, 2'b00, 2'b00, 1'b0,
                   5'd7, 2'd1, 5'd1, 8'h66, 1'b0, 1'b0, 3'd0, 1'b0);
        push(8'h58);
        expect_op("R10 opcode after two-byte vector", 8'h58);
        gap(1);
    endtask

    task automatic t_vex3;
        push(8'hC4);
        push(8'hE2);
        expect_quiet("R5 no record mid-payload");
        push(8'h7B);
        expect_rec("R5 R7 three-byte vector record, pp=3 -> F3", 3'd4, 2'b00, 2'b00, 2'b00, 1'b0,
                   5'd0, 2'd0, 5'd2, 8'hF3, 1'b0, 1'b0, 3'd0, 1'b0);
        push(8'hF7);
        expect_op("R10 opcode after three-byte vector", 8'hF7);
        gap(1);
    endtask

    task automatic t_vex3_stall;
        push(8'hC4);
        gap(2);
        push(8'h03);
        gap(3);
        push(8'h86);
        expect_rec("R9 R5 R7 stalled three-byte vector, pp=2 -> F2", 3'd4, 2'b01, 2'b01, 2'b01, 1'b1,
                   5'd15, 2'd1, 5'd3, 8'hF2, 1'b0, 1'b0, 3'd0, 1'b0);
        gap(2);
        push(8'h10);
        expect_op("R9 opcode accepted after stall", 8'h10);
        gap(1);
    endtask

    task automatic t_evex_a;
        push(8'h62);
        push(8'h71);
        push(8'h7D);
        expect_quiet("R6 no record before last payload");
        push(8'hCA);
        expect_rec("R6 four-byte vector record A", 3'd5, 2'b01, 2'b00, 2'b00, 1'b0,
                   5'd0, 2'd2, 5'd1, 8'h66, 1'b1, 1'b0, 3'd2, 1'b0);
        push(8'h28);
        expect_op("R10 opcode after four-byte vector", 8'h28);
        gap(1);
    endtask

    task automatic t_evex_b;
        push(8'h62);
        gap(1);
        push(8'h08);
        push(8'hC0);
        gap(1);
        push(8'h31);
        expect_rec("R6 R7 four-byte vector record B, pp=0 -> 00", 3'd5, 2'b11, 2'b11, 2'b11, 1'b1,
                   5'd23, 2'd1, 5'd0, 8'h00, 1'b0, 1'b1, 3'd1, 1'b0);
        push(8'hC5);
        expect_op("R10 vector lead value forwarded as opcode", 8'hC5);
        gap(1);
    endtask

    task automatic t_none;
        push(8'h90);
        expect_rec("R8 unmatched byte record", 3'd0, 2'b00, 2'b00, 2'b00, 1'b0,
                   5'd0, 2'd0, 5'd0, 8'h00, 1'b0, 1'b0, 3'd0, 1'b1);
        check("R8 unmatched byte forwarded", {56'd0, op_byte}, {56'd0, 8'h90});
        push(8'h0F);
        expect_rec("R8 second unmatched byte back to back", 3'd0, 2'b00, 2'b00, 2'b00, 1'b0,
                   5'd0, 2'd0, 5'd0, 8'h00, 1'b0, 1'b0, 3'd0, 1'b1);
        check("R8 second byte forwarded", {56'd0, op_byte}, {56'd0, 8'h0F});
        push(8'h41);
        expect_rec("R2 lead after unmatched bytes", 3'd1, 2'b00, 2'b00, 2'b01, 1'b0,
                   5'd0, 2'd0, 5'd0, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0);
        push(8'h01);
        expect_op("R10 opcode after one-byte reg-ext", 8'h01);
        gap(1);
    endtask

    initial begin
        t_reset();
        t_none();
        t_rex1();
        t_rex2();
        t_vex2();
        t_vex3();
        t_vex3_stall();
        t_evex_a();
        t_evex_b();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule